// File: doc/BRIEF.md
# Configurable SPI-style byte shifter

This block is an eight-bit serial port that moves one byte at a time over three lines: a data input, a data output and a shift clock. The host loads a byte into the shift register, picks the clock phase, the clock's rest level and which pins the block drives, and then raises `start` to mark the transfer busy. In master mode the block makes the shift clock itself by dividing the system clock. In slave mode it follows a clock that arrives on `sck_i`. That clock passes through a two-stage synchroniser, and its edges are detected in the system-clock domain.

Each transfer lasts exactly eight shift-clock pulses and is sent most-significant bit first. When the eighth pulse returns to its rest level, `busy` drops and all further clock edges are ignored until the host starts the next transfer. The host reads the received byte on `rd_data` at any time.

Top module: `spi_byte_port`

## Requirements
- R1: When `route_en` is 0, both `sck_oe` and `dout_oe` are 0. When `route_en` is 1, `sck_oe` follows `clk_drive` (1 means the block generates the clock) and `dout_oe` follows `dout_drive` (1 means the block drives data, 0 means the pin is released).
- R2: In master mode each clock level lasts DIV/2 system clocks. A transfer produces exactly 8 pulses, and `busy` stays high for 8*DIV clocks.
- R3: `start` sets `busy` only when `busy` is low, and a `start` while busy has no effect. `busy` clears on the edge that returns the eighth pulse to the rest level. It stays high until that edge.
- R4: With `phase_alt`=0, the bit on `din` is captured on a rising clock edge and `dout_o` changes on a falling edge. With `phase_alt`=1, capture is on the falling edge and `dout_o` changes on the rising edge.
- R5: Bit 7 of the shift register appears on `dout_o` one clock after `start` is accepted. Later bits follow from bit 6 down to bit 0. Captured bits enter at bit 0, so after a transfer `rd_data` holds the received byte with its first bit in bit 7.
- R6: Clock edges that arrive while `busy` is low change neither `rd_data` nor `dout_o`. The closing edge of the eighth pulse does not change `dout_o`, so `dout_o` keeps the last bit sent.
- R7: In slave mode, a change on `sck_i` takes effect at the third rising system-clock edge after the change. `din` is sampled at that same edge.
- R8: A write (`wr_en`) while busy is ignored. A write while idle appears on `rd_data` one clock later.
- R9: After reset, `busy`, `rd_data`, `dout_o` and `sck_o` are all 0.
- R10: With `idle_high`=1 the clock rests high, and with 0 it rests low. This choice is independent of `phase_alt`. In master mode, while not busy, `sck_o` equals `idle_high` one clock after it is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Load `wr_data` into the shift register (idle only) |
| wr_data | input | W | Byte to load |
| start | input | 1 | Set busy and begin a transfer |
| rd_data | output | W | Shift register contents |
| busy | output | 1 | Transfer in progress |
| route_en | input | 1 | Route serial functions onto the pins |
| clk_drive | input | 1 | 1: internal clock (master), 0: external clock (slave) |
| dout_drive | input | 1 | 1: drive data-out pin, 0: release it |
| phase_alt | input | 1 | 0: capture rising / change falling; 1: the reverse |
| idle_high | input | 1 | Rest level of the shift clock |
| sck_i | input | 1 | External shift clock (slave) |
| din | input | 1 | Serial data in |
| sck_o | output | 1 | Generated shift clock |
| sck_oe | output | 1 | Shift-clock pin drive enable |
| dout_o | output | 1 | Serial data out |
| dout_oe | output | 1 | Data-out pin drive enable |

## Verification
A pulse counter that is off by one shows at the ports at once: `busy` falls one pulse early or late, the master clock gives seven or nine pulses, and the received byte comes out shifted by one place. If the phase or rest-level decode is swapped, `dout_o` changes on the wrong edge within the first pulse, and `rd_data` differs from the byte the remote side sent. Every output is compared against a behavioural model on every clock, so any such fault is reported in the cycle it first appears. Directed slave transfers check the synchroniser latency and the MSB-first order end to end.

// File: rtl/sbp_pkg.sv
package sbp_pkg;

    localparam int unsigned BYTE_W = 8;

    // One-cycle strobes for the shift clock, in the system-clock domain
    typedef struct packed {
        logic rise;
        logic fall;
    } sck_evt_t;

    // What a given clock edge means to the shifter
    typedef struct packed {
        logic sample;   // capture din
        logic shift;    // present next bit on dout
        logic trail;    // edge returning the clock to rest level
    } shift_act_t;

    function automatic shift_act_t decode_edges(input sck_evt_t e,
                                                input logic phase_alt,
                                                input logic idle_high);
        shift_act_t a;
        a.sample = phase_alt ? e.fall : e.rise;
        a.shift  = phase_alt ? e.rise : e.fall;
        a.trail  = idle_high ? e.rise : e.fall;
        return a;
    endfunction

endpackage

// File: rtl/sbp_master_clk.sv
module sbp_master_clk
    import sbp_pkg::*;
#(
    parameter int unsigned DIV = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     run,
    input  logic     idle_high,
    output logic     sck,
    output sck_evt_t evt
);
    localparam int unsigned HALF = DIV / 2;
    localparam int unsigned CW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] half_cnt;
    logic          wrap;

    assign wrap = run && (half_cnt == CW'(HALF - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            half_cnt <= '0;
            sck      <= 1'b0;
        end else if (!run) begin
            half_cnt <= '0;
            sck      <= idle_high;
        end else if (wrap) begin
            half_cnt <= '0;
            sck      <= ~sck;
        end else begin
            half_cnt <= half_cnt + 1'b1;
        end
    end

    assign evt.rise = wrap && !sck;
    assign evt.fall = wrap &&  sck;

    AST_SCK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        !run |=> (sck == $past(idle_high)))
        else $error("clock not at rest level while stopped"); // R10

endmodule

// File: rtl/sbp_slave_sync.sv
module sbp_slave_sync
    import sbp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sck_pin,
    output sck_evt_t evt
);
    // [0],[1] synchroniser stages, [2] previous synchronised value
    logic [2:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[1:0], sck_pin};
    end

    assign evt.rise =  pipe[1] & ~pipe[2];
    assign evt.fall = ~pipe[1] &  pipe[2];

endmodule

// File: rtl/sbp_shift_core.sv
module sbp_shift_core
    import sbp_pkg::*;
#(
    parameter int unsigned W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         start,
    input  logic         din,
    input  shift_act_t   act,
    output logic [W-1:0] sr,
    output logic         dout,
    output logic         busy
);
    localparam int unsigned CNT_W = (W > 2) ? $clog2(W) : 1;

    logic [CNT_W-1:0] trail_cnt;
    logic             last_trail;

    assign last_trail = act.trail && (trail_cnt == CNT_W'(W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sr        <= '0;
            dout      <= 1'b0;
            busy      <= 1'b0;
            trail_cnt <= '0;
        end else if (busy) begin
            if (act.sample)
                sr <= {sr[W-2:0], din};
            if (act.shift && !last_trail)
                dout <= sr[W-1];
            if (act.trail) begin
                if (last_trail) begin
                    busy      <= 1'b0;
                    trail_cnt <= '0;
                end else begin
                    trail_cnt <= trail_cnt + 1'b1;
                end
            end
        end else begin
            if (wr_en)
                sr <= wr_data;
            if (start) begin
                busy      <= 1'b1;
                trail_cnt <= '0;
                dout      <= wr_en ? wr_data[W-1] : sr[W-1];
            end
        end
    end

    AST_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        busy && wr_en && !act.sample |=> sr == $past(sr))
        else $error("write while busy altered the register"); // R8

    AST_DOUT_ONLY_ON_SHIFT: assert property (@(posedge clk) disable iff (rst)
        busy && !act.shift |=> $stable(dout))
        else $error("data out moved without a shift edge"); // R4

    AST_BUSY_ENDS_ON_TRAIL: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $fell(busy) |-> $past(act.trail))
        else $error("busy cleared without a closing edge"); // R3

    AST_START_LOADS_MSB: assert property (@(posedge clk) disable iff (rst)
        !busy && start && !wr_en |=> dout == $past(sr[W-1]))
        else $error("first bit not presented on start"); // R5

endmodule

// File: rtl/spi_byte_port.sv
module spi_byte_port
    import sbp_pkg::*;
#(
    parameter int unsigned DIV = 4,
    parameter int unsigned W   = BYTE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         start,
    output logic [W-1:0] rd_data,
    output logic         busy,
    input  logic         route_en,
    input  logic         clk_drive,
    input  logic         dout_drive,
    input  logic         phase_alt,
    input  logic         idle_high,
    input  logic         sck_i,
    input  logic         din,
    output logic         sck_o,
    output logic         sck_oe,
    output logic         dout_o,
    output logic         dout_oe
);
    sck_evt_t   m_evt;
    sck_evt_t   s_evt;
    sck_evt_t   evt;
    shift_act_t act;
    logic       m_run;

    assign m_run = busy && clk_drive;

    sbp_master_clk #(.DIV(DIV)) u_mclk (
        .clk       (clk),
        .rst       (rst),
        .run       (m_run),
        .idle_high (idle_high),
        .sck       (sck_o),
        .evt       (m_evt)
    );

    sbp_slave_sync u_ssync (
        .clk     (clk),
        .rst     (rst),
        .sck_pin (sck_i),
        .evt     (s_evt)
    );

    assign evt = clk_drive ? m_evt : s_evt;
    assign act = decode_edges(evt, phase_alt, idle_high);

    sbp_shift_core #(.W(W)) u_core (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .start   (start),
        .din     (din),
        .act     (act),
        .sr      (rd_data),
        .dout    (dout_o),
        .busy    (busy)
    );

    assign sck_oe  = route_en && clk_drive;
    assign dout_oe = route_en && dout_drive;

endmodule

// File: tb/spi_byte_port_tb.sv
module spi_byte_port_tb;
    localparam int DIV  = 4;
    localparam int HALF = DIV / 2;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst, wr_en, start, busy;
    logic [7:0] wr_data, rd_data;
    logic       route_en, clk_drive, dout_drive, phase_alt, idle_high;
    logic       sck_i = 1'b0;
    logic       din;
    logic       sck_o, sck_oe, dout_o, dout_oe;
    logic       din_rand_en, din_slave;
    logic [15:0] lfsr = 16'hACE1;

    assign din = din_rand_en ? lfsr[0] : din_slave;
    always @(negedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};

    spi_byte_port #(.DIV(DIV), .W(8)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .start(start),
        .rd_data(rd_data), .busy(busy), .route_en(route_en), .clk_drive(clk_drive),
        .dout_drive(dout_drive), .phase_alt(phase_alt), .idle_high(idle_high),
        .sck_i(sck_i), .din(din), .sck_o(sck_o), .sck_oe(sck_oe),
        .dout_o(dout_o), .dout_oe(dout_oe)
    );

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [7:0] m_sr = '0;
    logic       m_dout = 1'b0, m_busy = 1'b0, m_sck = 1'b0;
    int         m_cnt = 0, m_t = 0;
    logic [3:0] hist = '0;

    always @(posedge clk) begin : model_blk
        logic er, ef, smp, shf, trl, fin;
        hist = {hist[2:0], sck_i};
        if (rst) begin
            m_sr = '0; m_dout = 1'b0; m_busy = 1'b0; m_sck = 1'b0; m_cnt = 0; m_t = 0;
        end else begin
            er = 1'b0; ef = 1'b0;
            if (clk_drive && m_busy) begin
                m_t++;
                if (m_t % HALF == 0) begin
                    if (m_sck) ef = 1'b1; else er = 1'b1;
                    m_sck = ~m_sck;
                end
            end else begin
                m_t = 0;
                m_sck = idle_high;
                if (!clk_drive) begin
                    er = hist[2] & ~hist[3];
                    ef = ~hist[2] & hist[3];
                end
            end
            if (m_busy) begin
                smp = phase_alt ? ef : er;
                shf = phase_alt ? er : ef;
                trl = idle_high ? er : ef;
                fin = trl && (m_cnt == 7);
                if (smp) m_sr = {m_sr[6:0], din};
                if (shf && !fin) m_dout = m_sr[7];
                if (trl) begin
                    if (fin) begin m_busy = 1'b0; m_cnt = 0; end
                    else m_cnt++;
                end
            end else begin
                if (wr_en) m_sr = wr_data;
                if (start) begin m_busy = 1'b1; m_cnt = 0; m_dout = m_sr[7]; end
            end
        end
    end

    // compare every clock, away from both edges
    always @(posedge clk) begin
        #5;
        if (!rst) begin
            cmp("R10/R2 sck_o vs model", sck_o, m_sck);
            cmp("R3 busy vs model", busy, m_busy);
            cmp("R4 dout_o vs model", dout_o, m_dout);
            cmp("R5 rd_data vs model", rd_data, m_sr);
            cmp("R1 sck_oe", sck_oe, route_en & clk_drive);
            cmp("R1 dout_oe", dout_oe, route_en & dout_drive);
        end
    end

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 60000) begin
            mismatched++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            summary();
            $finish;
        end
    end

    // ---------------- directed stimulus ----------------
    task automatic slave_xfer(input logic [7:0] tx, input logic [7:0] rx,
                              input logic alt, input logic idl, input bit poke);
        logic [7:0] got;
        logic smp_lead;
        got = '0;
        clk_drive = 1'b0; phase_alt = alt; idle_high = idl;
        sck_i = idl; din_rand_en = 1'b0; din_slave = 1'b0;
        repeat (6) @(negedge clk);
        wr_en = 1'b1; wr_data = tx; @(negedge clk);
        wr_en = 1'b0; start = 1'b1; @(negedge clk);
        start = 1'b0;
        cmp("R5 first bit on dout after start", dout_o, tx[7]);
        cmp("R3 busy set by start", busy, 1'b1);
        smp_lead = (alt == idl);
        for (int i = 0; i < 8; i++) begin
            din_slave = rx[7-i];
            if (smp_lead) got[7-i] = dout_o;
            sck_i = ~idl;
            repeat (5) @(negedge clk);
            if (poke && i == 3) begin
                wr_en = 1'b1; wr_data = 8'hFF; start = 1'b1; @(negedge clk);
                wr_en = 1'b0; start = 1'b0;
            end
            if (i == 7) cmp("R3 busy held before closing edge", busy, 1'b1);
            if (!smp_lead) got[7-i] = dout_o;
            sck_i = idl;
            repeat (5) @(negedge clk);
        end
        cmp("R3 busy cleared after eight pulses", busy, 1'b0);
        cmp("R7 slave received byte", rd_data, rx);
        cmp("R5 transmitted MSB first", got, tx);
        cmp("R6 dout keeps last bit after closing edge", dout_o, tx[0]);
        if (poke) cmp("R8 write while busy ignored", rd_data, rx);
    endtask

    task automatic master_xfer(input logic [7:0] tx, input logic alt, input logic idl);
        int n, pulses;
        logic prev;
        clk_drive = 1'b1; phase_alt = alt; idle_high = idl; din_rand_en = 1'b1;
        repeat (3) @(negedge clk);
        cmp("R10 master clock at rest level", sck_o, idl);
        wr_en = 1'b1; wr_data = tx; @(negedge clk);
        cmp("R8 idle write visible", rd_data, tx);
        wr_en = 1'b0; start = 1'b1; @(negedge clk);
        start = 1'b0;
        cmp("R5 master first bit", dout_o, tx[7]);
        n = 0; pulses = 0; prev = sck_o;
        while (busy && n < 1000) begin
            @(negedge clk);
            n++;
            if (sck_o != idl && prev == idl) pulses++;
            prev = sck_o;
        end
        cmp("R2 transfer length in clocks", n, 16 * HALF);
        cmp("R2 pulse count", pulses, 8);
        cmp("R10 clock back at rest level", sck_o, idl);
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_data = '0; start = 1'b0;
        route_en = 1'b0; clk_drive = 1'b0; dout_drive = 1'b0;
        phase_alt = 1'b0; idle_high = 1'b0; din_slave = 1'b0; din_rand_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cmp("R9 busy after reset", busy, 1'b0);
        cmp("R9 rd_data after reset", rd_data, 8'h00);
        cmp("R9 dout after reset", dout_o, 1'b0);
        cmp("R9 sck after reset", sck_o, 1'b0);
        @(negedge clk);

        // R1: every pin-enable combination
        for (int k = 0; k < 8; k++) begin
            route_en = k[0]; clk_drive = k[1]; dout_drive = k[2];
            #1;
            cmp("R1 sck_oe gating", sck_oe, k[0] & k[1]);
            cmp("R1 dout_oe gating", dout_oe, k[0] & k[2]);
            @(negedge clk);
        end
        route_en = 1'b1; dout_drive = 1'b1;

        // R4/R7/R10: slave transfers in all four phase/rest combinations
        slave_xfer(8'hA5, 8'h3C, 1'b0, 1'b0, 1'b0);
        slave_xfer(8'h96, 8'hC3, 1'b0, 1'b1, 1'b0);
        slave_xfer(8'h0F, 8'hF1, 1'b1, 1'b0, 1'b0);
        slave_xfer(8'h81, 8'h7E, 1'b1, 1'b1, 1'b0);
        // R8/R3: write and start while busy
        slave_xfer(8'h5A, 8'hB2, 1'b0, 1'b0, 1'b1);

        // R6: edges with busy low are ignored
        begin
            logic [7:0] keep_rd;
            logic keep_do;
            keep_rd = rd_data; keep_do = dout_o; din_slave = 1'b1;
            for (int p = 0; p < 3; p++) begin
                sck_i = 1'b1; repeat (5) @(negedge clk);
                sck_i = 1'b0; repeat (5) @(negedge clk);
            end
            cmp("R6 idle edges leave rd_data", rd_data, keep_rd);
            cmp("R6 idle edges leave dout", dout_o, keep_do);
        end

        // R2/R4/R10: master transfers in all four combinations
        master_xfer(8'hC9, 1'b0, 1'b0);
        master_xfer(8'h3E, 1'b0, 1'b1);
        master_xfer(8'h71, 1'b1, 1'b0);
        master_xfer(8'hD4, 1'b1, 1'b1);

        repeat (5) @(negedge clk);
        summary();
        $finish;
    end

endmodule